// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block generates all the traffic that an asynchronous DRAM needs apart from ordinary reads and writes. After reset it blocks every access for a fixed power-up pause. It then runs a burst of warm-up row cycles and raises a ready flag. From then on it keeps a periodic timer, so that every row of the array is refreshed well inside the retention window.

For each refresh the block asks the access sequencer for the memory bus with `refReq`. It starts a cycle only while `refGrant` is high, and it drives the row strobe, column strobe and write enable itself. Two refresh styles are available, chosen by `modeRasOnly`:

- **Column-before-row refresh.** The column strobe is lowered ahead of the row strobe, and no address is needed.
- **Row-only refresh.** The column strobe stays high, and an internal row counter is placed on the address pins, with `addrDrive` marking when the pins are driven.

The request goes up a programmable number of cycles before a refresh falls due. This gives the access sequencer time to close an open page. If refreshes fall due while the grant is withheld, they are counted up to a limit and then issued back to back once the bus is granted. An overflow of that count sets a sticky error.

If no row strobe has been seen for the retention time, either from this block or from the access sequencer (reported on `extRasActive`), the ready flag drops and the warm-up burst is repeated.

Top module: `refresh_sequencer`

## Requirements
- R1: While `rstN` is low, and in the first cycle after its release, `ramRasN`, `ramCasN` and `ramWeN` are 1, and `refReq`, `memReady`, `backlogErr` and `addrDrive` are 0.
- R2: After reset release, no row strobe falls during the first PAUSE_CYC clock cycles. The first warm-up cycle is requested in cycle PAUSE_CYC, and its row strobe falls CAS_LEAD+1 cycles after the first cycle in which the grant is high.
- R3: `memReady` rises only after exactly WARM_CNT row strobe pulses have completed since reset, or since the idle warm-up began.
- R4: While `memReady` is high and the grant follows the request, one refresh cycle is issued per REF_INTERVAL cycles on average.
- R5: With an empty backlog, `refReq` rises REQ_MARGIN cycles before the interval expires, and the row strobe falls REQ_MARGIN+CAS_LEAD+1 cycles after that rise. `refReq` stays high throughout every cycle, and no cycle starts while `refGrant` is low.
- R6: Every row strobe low pulse lasts exactly RAS_LOW cycles. Every row strobe high interval between two pulses lasts at least RAS_PRE+1 cycles.
- R7: In column-before-row mode (`modeRasOnly`=0), `ramCasN` falls exactly CAS_LEAD cycles before `ramRasN` falls, stays low until the row strobe rises, and `addrDrive` stays 0.
- R8: In row-only mode (`modeRasOnly`=1), `ramCasN` never goes low and `addrDrive` is 1 when the row strobe falls. `ramAddr` holds still during the low pulse, and it carries the row counter, which starts at 0 after reset and advances by one (modulo 2^ROW_W) after each cycle.
- R9: `ramWeN` is never driven low.
- R10: Refreshes that fall due without a grant are held, up to MAX_BACKLOG of them. When the grant arrives they are issued back to back, with a period of CAS_LEAD+RAS_LOW+RAS_PRE+1 cycles.
- R11: `backlogErr` sets when a refresh falls due while MAX_BACKLOG refreshes are already held. Once set, it stays set until reset, and it stays 0 as long as the grant is given in time.
- R12: While ready, the block counts cycles with no row strobe activity from itself or on `extRasActive`. After IDLE_LIMIT such cycles `memReady` drops and a new warm-up of WARM_CNT cycles runs. Any pulse on `extRasActive` restarts this count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeRasOnly | input | 1 | 1 selects row-only refresh with internal row counter, 0 selects column-before-row refresh; change only in reset |
| refGrant | input | 1 | Bus grant from the access sequencer |
| extRasActive | input | 1 | High in cycles where the access sequencer holds the row strobe low |
| refReq | output | 1 | Bus request to the access sequencer |
| memReady | output | 1 | Memory initialised and usable |
| backlogErr | output | 1 | Sticky: held-refresh count overflowed |
| ramRasN | output | 1 | Row strobe, active low |
| ramCasN | output | 1 | Column strobe, active low |
| ramWeN | output | 1 | Write enable, active low, held inactive |
| ramAddr | output | ROW_W | Refresh row address |
| addrDrive | output | 1 | High while `ramAddr` must be driven onto the address pins |

## Verification
The bench builds the block with a 50-cycle pause, eight warm-up cycles and a 40-cycle refresh interval with a 6-cycle early margin. It uses a 2-cycle column lead, a 5-cycle row low pulse, a 3-cycle precharge, a backlog limit of 3 and an idle limit of 150 cycles. With these values, the pause, the warm-up, the steady refresh rate and the early request timing all fit within a few hundred cycles, for both refresh styles and for several grant delays. Withholding the grant for a few hundred cycles overflows the backlog, and stopping the external strobe reports lets the idle timer expire. This brings the sticky error, the repeated warm-up and the back-to-back backlog burst into reach.

// File: rtl/refsq_pkg.sv
package refsq_pkg;
  typedef struct packed {
    logic start;
    logic rasOnly;
  } refStrobe_t;

  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_LOW, PH_PRE} cyclePhase_t;
  typedef enum logic [1:0] {ST_PAUSE, ST_WARM, ST_RUN} seqState_t;
endpackage

// File: rtl/refsq_shaper.sv
module refsq_shaper
  import refsq_pkg::*;
#(
  parameter int CAS_LEAD = 1,
  parameter int RAS_LOW  = 5,
  parameter int RAS_PRE  = 3,
  parameter int ROW_W    = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  refStrobe_t       strobe,
  output logic             dpIdle,
  output logic             rasActive,
  output logic             ramRasN,
  output logic             ramCasN,
  output logic [ROW_W-1:0] ramAddr,
  output logic             addrDrive
);
  localparam int MAX_PH = (CAS_LEAD > RAS_LOW) ?
                          ((CAS_LEAD > RAS_PRE) ? CAS_LEAD : RAS_PRE) :
                          ((RAS_LOW > RAS_PRE) ? RAS_LOW : RAS_PRE);
  localparam int CW = $clog2(MAX_PH + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(CAS_LEAD - 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(RAS_LOW - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(RAS_PRE - 1);

  cyclePhase_t      phase;
  logic [CW-1:0]    cnt;
  logic [ROW_W-1:0] rowQ;
  logic             rasOnlyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      rowQ     <= '0;
      rasOnlyQ <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (strobe.start) begin
          phase    <= PH_LEAD;
          cnt      <= LEAD_LAST;
          rasOnlyQ <= strobe.rasOnly;
        end
        PH_LEAD: if (cnt == '0) begin
          phase <= PH_LOW;
          cnt   <= LOW_LAST;
        end else cnt <= cnt - 1'b1;
        PH_LOW: if (cnt == '0) begin
          phase <= PH_PRE;
          cnt   <= PRE_LAST;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          phase <= PH_IDLE;
          if (rasOnlyQ) rowQ <= rowQ + 1'b1;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign dpIdle    = (phase == PH_IDLE);
  assign rasActive = (phase == PH_LOW);
  assign ramRasN   = ~rasActive;
  assign ramCasN   = ~(~rasOnlyQ & ((phase == PH_LEAD) | (phase == PH_LOW)));
  assign addrDrive = rasOnlyQ & ((phase == PH_LEAD) | (phase == PH_LOW));
  assign ramAddr   = rowQ;

  // R7: column strobe is already low in the cycle before the row strobe falls
  assert_cas_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ramRasN) && !ramCasN) |-> !$past(ramCasN));
  // R8: refresh row address holds still while the row strobe is low
  assert_row_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ramRasN && !$past(ramRasN)) |-> $stable(ramAddr));
  // R6: a row strobe rise is followed by at least one more high cycle
  assert_precharge_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramRasN) |=> ramRasN);
endmodule

// File: rtl/refsq_ctrl.sv
module refsq_ctrl
  import refsq_pkg::*;
#(
  parameter int PAUSE_CYC    = 50000,
  parameter int WARM_CNT     = 8,
  parameter int REF_INTERVAL = 1560,
  parameter int REQ_MARGIN   = 64,
  parameter int MAX_BACKLOG  = 8,
  parameter int IDLE_LIMIT   = 1640000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeRasOnly,
  input  logic       refGrant,
  input  logic       extRasActive,
  input  logic       dpIdle,
  input  logic       rasActive,
  output refStrobe_t strobe,
  output logic       refReq,
  output logic       memReady,
  output logic       backlogErr
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int WW = $clog2(WARM_CNT + 1);
  localparam int TW = $clog2(REF_INTERVAL + 1);
  localparam int BW = $clog2(MAX_BACKLOG + 1);
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam logic [PW-1:0] PAUSE_LAST  = PW'(PAUSE_CYC - 1);
  localparam logic [WW-1:0] WARM_INIT   = WW'(WARM_CNT);
  localparam logic [TW-1:0] TIMER_LAST  = TW'(REF_INTERVAL - 1);
  localparam logic [TW-1:0] REQ_AT      = TW'(REF_INTERVAL - REQ_MARGIN);
  localparam logic [BW-1:0] BACKLOG_MAX = BW'(MAX_BACKLOG);
  localparam logic [IW-1:0] IDLE_LAST   = IW'(IDLE_LIMIT - 1);

  seqState_t     state;
  logic [PW-1:0] pauseCnt;
  logic [WW-1:0] warmLeft;
  logic [TW-1:0] timer;
  logic [BW-1:0] pending;
  logic [IW-1:0] idleCnt;
  logic          errQ;
  logic          wrap, needCycle, takeOne, addOne, rasSeen;

  assign wrap      = (state != ST_PAUSE) && (timer == TIMER_LAST);
  assign needCycle = (state == ST_WARM) ? (warmLeft != '0)
                                        : ((state == ST_RUN) && (pending != '0));
  assign strobe.start   = (state != ST_PAUSE) && needCycle && refGrant && dpIdle;
  assign strobe.rasOnly = modeRasOnly;
  assign takeOne   = strobe.start && (state == ST_RUN);
  assign addOne    = wrap && ((pending != BACKLOG_MAX) || takeOne);
  assign rasSeen   = rasActive || extRasActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PAUSE;
      pauseCnt <= '0;
      warmLeft <= '0;
      timer    <= '0;
      pending  <= '0;
      idleCnt  <= '0;
      errQ     <= 1'b0;
    end else begin
      unique case (state)
        ST_PAUSE: if (pauseCnt == PAUSE_LAST) begin
          state    <= ST_WARM;
          warmLeft <= WARM_INIT;
        end else pauseCnt <= pauseCnt + 1'b1;
        ST_WARM: begin
          if (strobe.start) warmLeft <= warmLeft - 1'b1;
          else if ((warmLeft == '0) && dpIdle) begin
            state   <= ST_RUN;
            idleCnt <= '0;
          end
        end
        default: begin
          if (rasSeen) idleCnt <= '0;
          else if (idleCnt == IDLE_LAST) begin
            state    <= ST_WARM;
            warmLeft <= WARM_INIT;
            idleCnt  <= '0;
          end else idleCnt <= idleCnt + 1'b1;
        end
      endcase
      if (state != ST_PAUSE) timer <= wrap ? '0 : timer + 1'b1;
      pending <= pending + BW'(addOne) - BW'(takeOne);
      if (wrap && (pending == BACKLOG_MAX) && !takeOne) errQ <= 1'b1;
    end
  end

  assign refReq     = (state != ST_PAUSE) &&
                      (needCycle || !dpIdle || ((state == ST_RUN) && (timer >= REQ_AT)));
  assign memReady   = (state == ST_RUN);
  assign backlogErr = errQ;

  // R2: no refresh cycle is under way during the power-up pause
  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAUSE) |-> dpIdle);
  // R10: the held-refresh count never passes its limit
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    pending <= BACKLOG_MAX);
  // R11: the backlog error stays set once raised
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(errQ) |-> errQ);
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import refsq_pkg::*;
#(
  parameter int PAUSE_CYC    = 50000,
  parameter int WARM_CNT     = 8,
  parameter int REF_INTERVAL = 1560,
  parameter int REQ_MARGIN   = 64,
  parameter int MAX_BACKLOG  = 8,
  parameter int IDLE_LIMIT   = 1640000,
  parameter int CAS_LEAD     = 1,
  parameter int RAS_LOW      = 5,
  parameter int RAS_PRE      = 3,
  parameter int ROW_W        = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeRasOnly,
  input  logic             refGrant,
  input  logic             extRasActive,
  output logic             refReq,
  output logic             memReady,
  output logic             backlogErr,
  output logic             ramRasN,
  output logic             ramCasN,
  output logic             ramWeN,
  output logic [ROW_W-1:0] ramAddr,
  output logic             addrDrive
);
  refStrobe_t strobe;
  logic       dpIdle, rasActive;

  refsq_ctrl #(
    .PAUSE_CYC(PAUSE_CYC), .WARM_CNT(WARM_CNT), .REF_INTERVAL(REF_INTERVAL),
    .REQ_MARGIN(REQ_MARGIN), .MAX_BACKLOG(MAX_BACKLOG), .IDLE_LIMIT(IDLE_LIMIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .modeRasOnly(modeRasOnly), .refGrant(refGrant),
    .extRasActive(extRasActive), .dpIdle(dpIdle), .rasActive(rasActive),
    .strobe(strobe), .refReq(refReq), .memReady(memReady), .backlogErr(backlogErr)
  );

  refsq_shaper #(
    .CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE), .ROW_W(ROW_W)
  ) uShaper (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dpIdle(dpIdle), .rasActive(rasActive),
    .ramRasN(ramRasN), .ramCasN(ramCasN), .ramAddr(ramAddr), .addrDrive(addrDrive)
  );

  assign ramWeN = 1'b1;
endmodule

// File: tb/tb_refresh_sequencer.sv
module tb_refresh_sequencer;
  localparam int PAUSE_CYC = 50, WARM_CNT = 8, REF_INTERVAL = 40, REQ_MARGIN = 6;
  localparam int MAX_BACKLOG = 3, IDLE_LIMIT = 150, CAS_LEAD = 2, RAS_LOW = 5;
  localparam int RAS_PRE = 3, ROW_W = 10;
  localparam int ROWS = 1 << ROW_W;
  localparam int CYC_LEN = CAS_LEAD + RAS_LOW + RAS_PRE + 1;
  localparam int FF_BASE = PAUSE_CYC + 1 + CAS_LEAD;
  // stimulus and expected result: {row-only mode, grant lag, expected first fall cycle}
  localparam int VEC[4][3] = '{'{0, 0, FF_BASE}, '{1, 0, FF_BASE},
                                '{0, 3, FF_BASE + 3}, '{1, 5, FF_BASE + 5}};

  logic clk = 1'b0, rstN = 1'b0, modeRasOnly = 1'b0, refGrant = 1'b0, extRasActive = 1'b0;
  logic refReq, memReady, backlogErr, ramRasN, ramCasN, ramWeN, addrDrive;
  logic [ROW_W-1:0] ramAddr;

  int nChecks = 0, nFail = 0;
  int grantLag = 0, lagCnt = 0;
  bit grantEn = 1'b1;
  int cyc, fallCount, firstFall, expRow, lowRun, highRun, casLowRun;
  int reqRiseCyc, lastFallCyc;
  bit prevRas, prevReq, steady, casLowSeen, weLowSeen;

  always #5 clk = ~clk;

  refresh_sequencer #(
    .PAUSE_CYC(PAUSE_CYC), .WARM_CNT(WARM_CNT), .REF_INTERVAL(REF_INTERVAL),
    .REQ_MARGIN(REQ_MARGIN), .MAX_BACKLOG(MAX_BACKLOG), .IDLE_LIMIT(IDLE_LIMIT),
    .CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE), .ROW_W(ROW_W)
  ) dut (
    .clk(clk), .rstN(rstN), .modeRasOnly(modeRasOnly), .refGrant(refGrant),
    .extRasActive(extRasActive), .refReq(refReq), .memReady(memReady),
    .backlogErr(backlogErr), .ramRasN(ramRasN), .ramCasN(ramCasN), .ramWeN(ramWeN),
    .ramAddr(ramAddr), .addrDrive(addrDrive)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  // grant model: follows the request after grantLag cycles
  initial forever begin
    @(negedge clk);
    #2;
    if (grantEn && refReq && rstN) begin
      if (lagCnt >= grantLag) refGrant = 1'b1;
      else lagCnt++;
    end else begin
      refGrant = 1'b0;
      lagCnt = 0;
    end
  end

  // pulse monitor, sampled on the falling edge
  initial forever begin
    @(negedge clk);
    if (rstN) begin
      cyc++;
      if (!ramWeN) weLowSeen = 1'b1;
      if (modeRasOnly && !ramCasN) casLowSeen = 1'b1;
      if (refReq && !prevReq) reqRiseCyc = cyc;
      if (prevRas && !ramRasN) begin
        fallCount++;
        if (fallCount == 1) begin
          firstFall = cyc;
          check(!memReady, "R2 ready low at first strobe", memReady, 0);
        end
        if (!modeRasOnly) begin
          check(casLowRun == CAS_LEAD, "R7 column lead", casLowRun, CAS_LEAD);
          check(!addrDrive, "R7 address not driven", addrDrive, 0);
        end else begin
          check(ramAddr == ROW_W'(expRow), "R8 row address", ramAddr, expRow);
          check(addrDrive, "R8 address driven", addrDrive, 1);
          expRow = (expRow + 1) % ROWS;
        end
        if (fallCount > 1)
          check(highRun >= RAS_PRE + 1, "R6 precharge", highRun, RAS_PRE + 1);
        check(refReq, "R5 request held in cycle", refReq, 1);
        if (steady && reqRiseCyc > lastFallCyc)
          check(cyc - reqRiseCyc == REQ_MARGIN + 1 + CAS_LEAD, "R5 early request",
                cyc - reqRiseCyc, REQ_MARGIN + 1 + CAS_LEAD);
        lastFallCyc = cyc;
        highRun = 0;
      end
      if (!prevRas && ramRasN) begin
        check(lowRun == RAS_LOW, "R6 low width", lowRun, RAS_LOW);
        lowRun = 0;
      end
      if (ramRasN) highRun++;
      else lowRun++;
      if (!ramCasN) casLowRun++;
      else casLowRun = 0;
      prevRas = ramRasN;
      prevReq = refReq;
    end
  end

  task automatic doReset(input bit mode, input int lag);
    @(negedge clk);
    rstN = 1'b0;
    modeRasOnly = mode;
    grantLag = lag;
    grantEn = 1'b1;
    extRasActive = 1'b0;
    repeat (3) @(negedge clk);
    check(ramRasN && ramCasN && ramWeN, "R1 strobes idle in reset",
          {ramRasN, ramCasN, ramWeN}, 7);
    check(!refReq && !memReady && !backlogErr && !addrDrive, "R1 flags low in reset",
          {refReq, memReady, backlogErr, addrDrive}, 0);
    #1;
    cyc = 0; fallCount = 0; firstFall = 0; expRow = 0; lowRun = 0; highRun = 0;
    casLowRun = 0; reqRiseCyc = 0; lastFallCyc = 0; prevRas = 1'b1; prevReq = 1'b0;
    steady = 1'b0; casLowSeen = 1'b0; weLowSeen = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(!refReq && !memReady && ramRasN, "R1 first cycle after release",
          {refReq, memReady, ramRasN}, 1);
  endtask

  task automatic waitReady(input bit level, input int limit, output int waited);
    waited = 0;
    while (memReady != level && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finishRun();
  end

  initial begin
    int waited, f0;
    for (int i = 0; i < 4; i++) begin
      doReset(VEC[i][0] != 0, VEC[i][1]);
      waitReady(1'b1, 2000, waited);
      check(memReady, "R3 ready reached", memReady, 1);
      check(fallCount == WARM_CNT, "R3 warm-up count", fallCount, WARM_CNT);
      check(firstFall == VEC[i][2], "R2 first strobe cycle", firstFall, VEC[i][2]);
      repeat (2 * REF_INTERVAL) @(negedge clk);
      steady = 1'b1;
      f0 = fallCount;
      repeat (10 * REF_INTERVAL) @(negedge clk);
      steady = 1'b0;
      check(fallCount - f0 >= 9 && fallCount - f0 <= 11, "R4 refresh rate",
            fallCount - f0, 10);
      check(!backlogErr, "R11 no error when granted", backlogErr, 0);
      check(memReady, "R12 stays ready while refreshing", memReady, 1);
      if (VEC[i][0] != 0) check(!casLowSeen, "R8 column strobe never low", casLowSeen, 0);
      check(!weLowSeen, "R9 write enable inactive", weLowSeen, 0);
    end

    // directed: grant withheld, external strobe activity, idle expiry, backlog burst
    doReset(1'b0, 0);
    waitReady(1'b1, 2000, waited);
    repeat (2 * REF_INTERVAL) @(negedge clk);
    #1 grantEn = 1'b0;
    repeat (5) @(negedge clk);
    f0 = fallCount;
    for (int k = 0; k < 6; k++) begin
      repeat (40) @(negedge clk);
      check(memReady, "R12 external strobes keep ready", memReady, 1);
      #1 extRasActive = 1'b1;
      @(negedge clk);
      #1 extRasActive = 1'b0;
    end
    check(fallCount == f0, "R5 no cycle without grant", fallCount - f0, 0);
    check(backlogErr, "R11 backlog overflow flagged", backlogErr, 0 + 1);
    waitReady(1'b0, 400, waited);
    check(waited >= IDLE_LIMIT - 3 && waited <= IDLE_LIMIT + 3, "R12 idle expiry",
          waited, IDLE_LIMIT);
    f0 = fallCount;
    #1 grantEn = 1'b1;
    waitReady(1'b1, 2000, waited);
    check(fallCount - f0 == WARM_CNT, "R12 warm-up repeated", fallCount - f0, WARM_CNT);
    f0 = fallCount;
    repeat (3 * CYC_LEN) @(negedge clk);
    check(fallCount - f0 == MAX_BACKLOG, "R10 backlog burst", fallCount - f0, MAX_BACKLOG);
    check(backlogErr, "R11 error sticky", backlogErr, 1);
    check(!weLowSeen, "R9 write enable inactive", weLowSeen, 0);
    finishRun();
  end
endmodule